// File: doc/BRIEF.md
# IO Page Access Decoder with Bus-Error Aggregation

This block sits between a CPU bus port and the memory-mapped IO page at the top of a 24-bit address space. Each request carries an address, a transfer size (byte, word or long), a write flag and write data. The block folds aliased register addresses onto their home location and splits multi-byte transfers into byte lanes. Every lane is classified as a register byte, a void byte or an error byte. The block then answers with either an acknowledge plus read data, or a bus-error response.

A small on-block register array stands in for the peripherals behind the page. Two configuration inputs switch optional windows on or off: a 64-byte block-copy engine window and a clock/calendar window. A bus error is raised only when every byte lane of the transfer falls on an error byte. Whenever the block raises a bus error, it also records the truncated, unaliased base address and the size, so that an exception handler can report them.

Top module: `io_space_decoder`

## Requirements
- R1: Only the low 24 bits of `addr_i` are decoded. Any access whose 24-bit address lies below 0xFF8000 gets a bus error, and no lane is classified.
- R2: Inside the page 0xFF8000..0xFFFFFF, a byte is an error byte unless R3, R6 or R7 claims it. A byte access to an error byte gets a bus error.
- R3: A base address in 0xFF8800..0xFF88FF is folded to 0xFF8800 plus its low two bits. Any lane address in that range selects sound register byte (address mod 4).
- R4: Sizes are encoded as 0 = byte (1 lane), 1 = word (2 lanes) and 2 or 3 = long (4 lanes). A bus error is raised only when the number of error lanes equals the lane count. Otherwise the access is acknowledged.
- R5: In an acknowledged read, every error lane and every void lane returns 0xFF.
- R6: When `rtc_en_i` is 1, bytes 0xFFFC21..0xFFFC3F are read/write registers. When it is 0, they are void: reads return 0xFF and writes are acknowledged with no effect. 0xFFFC20 is always an error byte.
- R7: When `blit_en_i` is 1, bytes 0xFF8A00..0xFF8A3F are read/write registers. When it is 0, they are error bytes.
- R8: On every bus error, `flt_addr_o` takes the 24-bit unfolded base address and `flt_size_o` takes `size_i`. Both hold their values until the next bus error.
- R9: A word access with a base above 0xFFFFFE, or a long access with a base above 0xFFFFFC, is illegal. It is acknowledged with read data 0xFFFFFFFF and updates nothing.
- R10: Lanes are big-endian and right-justified. The lowest address maps to bits [8n-1:8n-8] of the data for an n-byte access, and unused upper bits read 0.
- R11: A request sampled at a rising edge is answered at the next edge by exactly one of `ack_o` or `berr_o`, together with `rdata_o`. No response appears without a request. Write and bus-error responses carry `rdata_o` = 0.
- R12: A write updates only register lanes. A faulting write changes no register byte.
- R13: A synchronous active-low reset clears all outputs and every register byte to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 word, 2/3 long |
| addr_i | input | 32 | Byte address (low 24 bits used) |
| wdata_i | input | 32 | Write data, right-justified |
| blit_en_i | input | 1 | Enables the block-copy register window |
| rtc_en_i | input | 1 | Enables the clock/calendar register window |
| ack_o | output | 1 | Access completed |
| berr_o | output | 1 | Access faulted |
| rdata_o | output | 32 | Read data, right-justified |
| flt_addr_o | output | 24 | Base address of the last fault |
| flt_size_o | output | 2 | Size of the last fault |

## Verification
The delicate case is a single transfer that straddles a register byte and an error byte. In one cycle, the register lane must commit or return its value while the error lane is suppressed, and no bus error may be raised. This is provoked with word and long accesses across the top edge of the block-copy window, both for writes and for reads. Each is judged by reading back the register byte afterwards and by comparing the 0xFF fill in the error lanes. Lane folding inside the alias range is checked the same way, with a long read whose upper lanes wrap back onto register 0.

// File: rtl/io_dec_pkg.sv
// Package: shared constants and types for the IO page decoder.
// Assumes a 24-bit decoded address and at most four byte lanes per access.
package io_dec_pkg;
    localparam int unsigned ADDR_W    = 24;
    localparam int unsigned LANES     = 4;
    localparam int unsigned REG_BYTES = 128;
    localparam int unsigned IDX_W     = $clog2(REG_BYTES);

    // Register array layout: base index of each peripheral bank
    localparam int unsigned SND_BASE  = 0;
    localparam int unsigned RTC_BASE  = 32;
    localparam int unsigned BLT_BASE  = 64;

    localparam logic [ADDR_W-1:0] PAGE_LO  = 24'hFF8000;
    localparam logic [ADDR_W-1:0] SND_LO   = 24'hFF8800;
    localparam logic [ADDR_W-1:0] SND_HI   = 24'hFF88FF;
    localparam logic [ADDR_W-1:0] BLT_LO   = 24'hFF8A00;
    localparam logic [ADDR_W-1:0] BLT_HI   = 24'hFF8A3F;
    localparam logic [ADDR_W-1:0] RTC_LO   = 24'hFFFC21;
    localparam logic [ADDR_W-1:0] RTC_HI   = 24'hFFFC3F;
    localparam logic [ADDR_W-1:0] WORD_MAX = 24'hFFFFFE;
    localparam logic [ADDR_W-1:0] LONG_MAX = 24'hFFFFFC;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} acc_size_e;
    typedef enum logic [1:0] {LANE_ERR = 2'd0, LANE_VOID = 2'd1, LANE_REG = 2'd2} lane_kind_e;
endpackage

// File: rtl/io_lane_class.sv
// Module: classifies one byte-lane address as register, void or error byte,
// and gives the register-array index for register bytes.
// Assumes the lane address has already had its base folded for aliasing.
module io_lane_class
    import io_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] lane_addr_i,
    input  logic              blit_en_i,
    input  logic              rtc_en_i,
    output lane_kind_e        kind_o,
    output logic [IDX_W-1:0]  idx_o
);
    // Decode the lane address against the optional and fixed windows
    always_comb begin
        kind_o = LANE_ERR;
        idx_o  = '0;
        if (lane_addr_i >= SND_LO && lane_addr_i <= SND_HI) begin
            kind_o = LANE_REG;
            idx_o  = IDX_W'(SND_BASE) + IDX_W'(lane_addr_i[1:0]);
        end else if (lane_addr_i >= BLT_LO && lane_addr_i <= BLT_HI) begin
            if (blit_en_i) begin
                kind_o = LANE_REG;
                idx_o  = IDX_W'(BLT_BASE) + IDX_W'(lane_addr_i[5:0]);
            end
        end else if (lane_addr_i >= RTC_LO && lane_addr_i <= RTC_HI) begin
            if (rtc_en_i) begin
                kind_o = LANE_REG;
                idx_o  = IDX_W'(RTC_BASE) + IDX_W'(lane_addr_i[4:0]);
            end else begin
                kind_o = LANE_VOID;
            end
        end
    end
endmodule

// File: rtl/io_reg_bank.sv
// Module: byte-wide register array standing in for the peripherals.
// One write port and one read port per lane; assumes the lanes of one
// access never target the same byte in the same cycle.
module io_reg_bank
    import io_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] we_i,
    input  logic [IDX_W-1:0] widx_i  [LANES],
    input  logic [7:0]       wbyte_i [LANES],
    input  logic [IDX_W-1:0] ridx_i  [LANES],
    output logic [7:0]       rbyte_o [LANES]
);
    logic [7:0] mem [REG_BYTES];

    // Clear on reset, else commit each enabled lane to its byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_BYTES; i++) mem[i] <= 8'h00;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we_i[l]) mem[widx_i[l]] <= wbyte_i[l];
            end
        end
    end

    // Asynchronous read of each lane
    always_comb begin
        for (int l = 0; l < LANES; l++) rbyte_o[l] = mem[ridx_i[l]];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R12
        lane_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we_i[l] |=> mem[$past(widx_i[l])] == $past(wbyte_i[l]));
        for (genvar m = l + 1; m < LANES; m++) begin : g_pair
            // R3
            lane_idx_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(we_i[l] && we_i[m] && widx_i[l] == widx_i[m]));
        end
    end
endmodule

// File: rtl/io_space_decoder.sv
// Module: top of the IO page decoder. Folds aliases, splits the access into
// lanes, aggregates error lanes and returns a registered ack or bus error.
// Assumes one request at a time; a response always comes one cycle later.
module io_space_decoder
    import io_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [31:0]       addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              blit_en_i,
    input  logic              rtc_en_i,
    output logic              ack_o,
    output logic              berr_o,
    output logic [31:0]       rdata_o,
    output logic [ADDR_W-1:0] flt_addr_o,
    output logic [1:0]        flt_size_o
);
    logic [ADDR_W-1:0] a24, base_addr;
    logic [ADDR_W-1:0] lane_addr [LANES];
    lane_kind_e        lane_kind [LANES];
    logic [IDX_W-1:0]  lane_idx  [LANES];
    logic [7:0]        lane_wbyte[LANES];
    logic [7:0]        lane_rbyte[LANES];
    logic [LANES-1:0]  lane_we;
    logic [2:0]        nbytes, err_cnt;
    logic              below, illegal, all_err, fault;
    logic [31:0]       rd_next;

    // Truncate, check range and fold the alias window on the base address
    always_comb begin
        a24     = addr_i[ADDR_W-1:0];
        nbytes  = (size_i == SZ_BYTE) ? 3'd1 : (size_i == SZ_WORD) ? 3'd2 : 3'd4;
        below   = a24 < PAGE_LO;
        illegal = (size_i == SZ_WORD && a24 > WORD_MAX) ||
                  (size_i[1] && a24 > LONG_MAX);
        base_addr = (a24 >= SND_LO && a24 <= SND_HI) ?
                    (SND_LO | {{(ADDR_W-2){1'b0}}, a24[1:0]}) : a24;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k] = base_addr + ADDR_W'(k);
        io_lane_class u_cls (
            .lane_addr_i (lane_addr[k]),
            .blit_en_i   (blit_en_i),
            .rtc_en_i    (rtc_en_i),
            .kind_o      (lane_kind[k]),
            .idx_o       (lane_idx[k])
        );
    end

    // Count error lanes among the active ones and decide the fault
    always_comb begin
        err_cnt = 3'd0;
        for (int k = 0; k < LANES; k++) begin
            if (3'(k) < nbytes && lane_kind[k] == LANE_ERR) err_cnt = err_cnt + 3'd1;
        end
        all_err = (err_cnt == nbytes);
        fault   = below || (!illegal && all_err);
    end

    // Steer write bytes into lanes and pack read lanes big-endian
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_wbyte[k] = 8'h00;
            lane_we[k]    = 1'b0;
            if (3'(k) < nbytes) begin
                lane_wbyte[k] = wdata_i[8*(int'(nbytes)-1-k) +: 8];
                lane_we[k]    = req_i && we_i && !fault && !illegal &&
                                lane_kind[k] == LANE_REG;
                rd_next[8*(int'(nbytes)-1-k) +: 8] =
                    (lane_kind[k] == LANE_REG) ? lane_rbyte[k] : 8'hFF;
            end
        end
    end

    io_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lane_we),
        .widx_i  (lane_idx),
        .wbyte_i (lane_wbyte),
        .ridx_i  (lane_idx),
        .rbyte_o (lane_rbyte)
    );

    // Register the response and capture the fault report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o      <= 1'b0;
            berr_o     <= 1'b0;
            rdata_o    <= '0;
            flt_addr_o <= '0;
            flt_size_o <= '0;
        end else begin
            ack_o   <= req_i && !fault;
            berr_o  <= req_i && fault;
            rdata_o <= (req_i && !we_i && !fault) ? (illegal ? 32'hFFFF_FFFF : rd_next) : '0;
            if (req_i && fault) begin
                flt_addr_o <= a24;
                flt_size_o <= size_i;
            end
        end
    end

    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && berr_o));
    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (ack_o || berr_o));
    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!ack_o && !berr_o));
    // R8
    flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_o |-> ($stable(flt_addr_o) && $stable(flt_size_o)));
endmodule

// File: tb/io_space_decoder_tb.sv
// Bench: vector table walked by one loop, then directed reset and fault-report tests.
module io_space_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, blit = 1'b1, rtc = 1'b1;
    logic [1:0]  sz = 2'd0;
    logic [31:0] addr = '0, wd = '0;
    logic        ack, berr;
    logic [31:0] rdata;
    logic [23:0] flt_addr;
    logic [1:0]  flt_size;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    io_space_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .size_i(sz),
        .addr_i(addr), .wdata_i(wd), .blit_en_i(blit), .rtc_en_i(rtc),
        .ack_o(ack), .berr_o(berr), .rdata_o(rdata),
        .flt_addr_o(flt_addr), .flt_size_o(flt_size)
    );

    typedef struct packed {
        logic        w;
        logic [1:0]  s;
        logic [31:0] a;
        logic [31:0] d;
        logic        bl;
        logic        rt;
        logic        eb;
        logic [31:0] er;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd1, 32'h00FF8A00, 32'h00001234, 1'b1, 1'b1, 1'b0, 32'h00000000, 4'd7 },  // R7 word write
        '{1'b0, 2'd1, 32'h00FF8A00, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00001234, 4'd10},  // R10
        '{1'b0, 2'd0, 32'h00FF8A01, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00000034, 4'd10},  // R10
        '{1'b0, 2'd2, 32'h00FF8A00, 32'h0,        1'b1, 1'b1, 1'b0, 32'h12340000, 4'd10},  // R10
        '{1'b1, 2'd2, 32'h00FF8800, 32'hAABBCCDD, 1'b1, 1'b1, 1'b0, 32'h00000000, 4'd3 },  // R3
        '{1'b0, 2'd0, 32'h00FF8841, 32'h0,        1'b1, 1'b1, 1'b0, 32'h000000BB, 4'd3 },  // R3 fold
        '{1'b0, 2'd1, 32'h00FF88FE, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0000CCDD, 4'd3 },  // R3 fold
        '{1'b0, 2'd2, 32'h00FF88F2, 32'h0,        1'b1, 1'b1, 1'b0, 32'hCCDDAABB, 4'd3 },  // R3 lane wrap
        '{1'b0, 2'd0, 32'h00FF8204, 32'h0,        1'b1, 1'b1, 1'b1, 32'h00000000, 4'd2 },  // R2
        '{1'b0, 2'd1, 32'h00FF8A3F, 32'h0,        1'b1, 1'b1, 1'b0, 32'h000000FF, 4'd4 },  // R4 partial
        '{1'b0, 2'd1, 32'h00FF8A40, 32'h0,        1'b1, 1'b1, 1'b1, 32'h00000000, 4'd4 },  // R4 full
        '{1'b1, 2'd1, 32'h00FF8A3F, 32'h00007788, 1'b1, 1'b1, 1'b0, 32'h00000000, 4'd12},  // R12 partial write
        '{1'b0, 2'd0, 32'h00FF8A3F, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00000077, 4'd12},  // R12
        '{1'b0, 2'd2, 32'h00FF8A3E, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0077FFFF, 4'd5 },  // R5
        '{1'b1, 2'd2, 32'h00FF8A40, 32'hDEADBEEF, 1'b1, 1'b1, 1'b1, 32'h00000000, 4'd12},  // R12 faulting write
        '{1'b0, 2'd2, 32'h00FF8A3C, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00000077, 4'd12},  // R12
        '{1'b0, 2'd0, 32'h00000100, 32'h0,        1'b1, 1'b1, 1'b1, 32'h00000000, 4'd1 },  // R1 below page
        '{1'b0, 2'd0, 32'h12FF8A3F, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00000077, 4'd1 },  // R1 truncation
        '{1'b0, 2'd1, 32'h00FFFFFF, 32'h0,        1'b1, 1'b1, 1'b0, 32'hFFFFFFFF, 4'd9 },  // R9
        '{1'b1, 2'd2, 32'h00FFFFFD, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00000000, 4'd9 },  // R9
        '{1'b1, 2'd0, 32'h00FFFC25, 32'h0000005A, 1'b1, 1'b1, 1'b0, 32'h00000000, 4'd6 },  // R6
        '{1'b0, 2'd0, 32'h00FFFC25, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0000005A, 4'd6 },  // R6
        '{1'b0, 2'd0, 32'h00FFFC25, 32'h0,        1'b1, 1'b0, 1'b0, 32'h000000FF, 4'd6 },  // R6 void read
        '{1'b1, 2'd0, 32'h00FFFC25, 32'h00000011, 1'b1, 1'b0, 1'b0, 32'h00000000, 4'd6 },  // R6 void write
        '{1'b0, 2'd0, 32'h00FFFC25, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0000005A, 4'd6 },  // R6 no effect
        '{1'b0, 2'd0, 32'h00FFFC20, 32'h0,        1'b1, 1'b1, 1'b1, 32'h00000000, 4'd6 },  // R6 edge
        '{1'b0, 2'd1, 32'h00FFFC20, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0000FFFF, 4'd5 },  // R5 err+void
        '{1'b0, 2'd0, 32'h00FF8A01, 32'h0,        1'b0, 1'b1, 1'b1, 32'h00000000, 4'd7 },  // R7 disabled
        '{1'b1, 2'd0, 32'h00FF8A01, 32'h00000099, 1'b0, 1'b1, 1'b1, 32'h00000000, 4'd7 },  // R7
        '{1'b0, 2'd0, 32'h00FF8A01, 32'h0,        1'b1, 1'b1, 1'b0, 32'h00000034, 4'd7 },  // R7 unchanged
        '{1'b0, 2'd2, 32'h00FF8A00, 32'h0,        1'b0, 1'b1, 1'b1, 32'h00000000, 4'd7 }   // R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] s, input logic [31:0] a,
                          input logic [31:0] d, input logic bl, input logic rt);
        @(negedge clk);
        req = 1'b1; we = w; sz = s; addr = a; wd = d; blit = bl; rtc = rt;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 reset outputs", {ack, berr, rdata[29:0]}, 32'h0);
        check("R13 reset fault report", {6'd0, flt_size, flt_addr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 no response without request
        check("R11 idle", {30'd0, ack, berr}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].w, VECS[i].s, VECS[i].a, VECS[i].d, VECS[i].bl, VECS[i].rt);
            // R11 exactly one response, data alongside
            check($sformatf("R%0d vec%0d resp", VECS[i].rq, i), {30'd0, ack, berr},
                  {30'd0, !VECS[i].eb, VECS[i].eb});
            check($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), rdata, VECS[i].er);
        end

        // R8 fault report captures truncated base and size
        access(1'b0, 2'd3, 32'h55000100, 32'h0, 1'b1, 1'b1);
        check("R8 flt addr below page", {8'd0, flt_addr}, 32'h00000100);
        check("R8 flt size long", {30'd0, flt_size}, 32'd3);
        access(1'b0, 2'd1, 32'h00FF88F1, 32'h0, 1'b1, 1'b1);
        check("R8 held after ack", {6'd0, flt_size, flt_addr}, {6'd0, 2'd3, 24'h000100});
        access(1'b0, 2'd0, 32'hABFF8204, 32'h0, 1'b1, 1'b1);
        check("R8 flt addr in page", {6'd0, flt_size, flt_addr}, {6'd0, 2'd0, 24'hFF8204});
        @(negedge clk);
        // R11 response lasts one cycle
        check("R11 single-cycle", {30'd0, ack, berr}, 32'h0);

        // R13 mid-run reset clears registers and outputs
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R13 reset clears report", {6'd0, flt_size, flt_addr}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 2'd2, 32'h00FF8800, 32'h0, 1'b1, 1'b1);
        check("R13 sound regs cleared", rdata, 32'h0);
        access(1'b0, 2'd1, 32'h00FF8A00, 32'h0, 1'b1, 1'b1);
        check("R13 copy regs cleared", rdata, 32'h0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule